// File: doc/BRIEF.md
# Return Address Stack Predictor

This block predicts the targets of subroutine returns in an instruction fetch front end. A single target buffer keeps one target per branch, so it cannot follow a routine that is called from many places. This block keeps a small last-in, first-out store of return addresses instead. When the front end flags a call, the block stores the address of the instruction that follows the call. When it flags a return, the block removes the newest stored address and offers it as the predicted target in the same cycle.

The store is a circular buffer of fixed depth with an occupancy count. A build-time parameter picks what happens when a call arrives while the store is full. The wrap policy advances the top pointer and overwrites the oldest entry, so the newest addresses are kept. The drop policy ignores the call and leaves the stored addresses as they were. Full and empty flags report the occupancy. Repair after a misprediction, and deciding which instructions are calls or returns, are handled elsewhere.

Top module: `ret_addr_stack`

## Requirements
- R1: In the cycle after synchronous reset, `empty_o` is 1, `full_o` is 0 and `pred_valid_o` is 0.
- R2: A push stores `push_pc_i + 4` (instructions are 4 bytes and addresses are 32 bits). A later pop that reaches that entry drives it on `pred_target_o` with `pred_valid_o` high, in the same cycle as `pop_i`.
- R3: Pops return the pushed addresses newest first.
- R4: A pop on an empty stack drives `pred_valid_o` low and changes neither the pointer nor the occupancy. A following push and pop still return the pushed address.
- R5: `full_o` is 1 exactly when the occupancy equals DEPTH (default 4), and `empty_o` is 1 exactly when the occupancy is 0. The two flags are never high together.
- R6: With POLICY = OVF_WRAP, a push while full overwrites the oldest entry and keeps the occupancy at DEPTH. The next DEPTH pops return the newest DEPTH addresses, and the pop after them finds the stack empty.
- R7: With POLICY = OVF_DROP, a push while full is ignored. The next DEPTH pops return the addresses that were stored before that push.
- R8: A push and a pop in the same cycle act as a pop followed by a push. If the stack is not empty, the prediction is the old top entry, the top entry is replaced by the new address, and the occupancy stays the same. If the stack is empty, the prediction is invalid and the push goes ahead.
- R9: `pred_valid_o` is high only in a cycle where `pop_i` is high and the stack is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | A call is being fetched |
| push_pc_i | input | 32 | Address of the call instruction |
| pop_i | input | 1 | A return is being fetched |
| pred_target_o | output | 32 | Predicted return address |
| pred_valid_o | output | 1 | The prediction is usable |
| full_o | output | 1 | Occupancy equals DEPTH |
| empty_o | output | 1 | Occupancy is zero |

## Verification
A wrong top pointer shows up on the very next pop: `pred_target_o` carries a neighbouring entry's address instead of the one expected. A wrong occupancy count shows up in `full_o` or `empty_o` one cycle after the push or pop that caused it. It can also show up later, after several pops, when `pred_valid_o` stays high past the real bottom of the stack or goes low too early. Most of these faults only become visible at the edges: on an overflow, on a pop while empty, or on a push and pop in the same cycle. For that reason the tests drain the stack to empty after each such event and check every address along the way.

// File: rtl/ras_pkg.sv
package ras_pkg;

    localparam int RAS_ADDR_W     = 32;
    localparam int RAS_INST_BYTES = 4;

    typedef logic [RAS_ADDR_W-1:0] ras_addr_t;

    typedef enum logic {
        OVF_WRAP = 1'b0,
        OVF_DROP = 1'b1
    } ras_ovf_e;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } ras_op_e;

    typedef struct packed {
        logic push;
        logic pop;
    } ras_req_t;

    function automatic ras_addr_t ras_ret_addr(input ras_addr_t call_pc);
        return call_pc + ras_addr_t'(RAS_INST_BYTES);
    endfunction

    function automatic ras_op_e ras_decode(input ras_req_t req, input logic nonempty);
        ras_op_e op;
        op = OP_IDLE;
        if (req.push && req.pop && nonempty) op = OP_SWAP;
        else if (req.pop && nonempty)        op = OP_POP;
        else if (req.push)                   op = OP_PUSH;
        return op;
    endfunction

endpackage

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  ras_pkg::ras_addr_t       wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output ras_pkg::ras_addr_t       rd_data
);
    import ras_pkg::*;

    ras_addr_t slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                slot[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = slot[i];
        end
    end

endmodule

// File: rtl/ras_ptr_ctrl.sv
module ras_ptr_ctrl #(
    parameter int                DEPTH  = 4,
    parameter int                IDX_W  = 2,
    parameter int                CNT_W  = 3,
    parameter ras_pkg::ras_ovf_e POLICY = ras_pkg::OVF_WRAP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [IDX_W-1:0] top_idx,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             pop_hit,
    output logic             full,
    output logic             empty
);
    import ras_pkg::*;

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] top_q, top_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    ras_op_e          op;
    ras_req_t         req;

    function automatic logic [IDX_W-1:0] idx_inc(input logic [IDX_W-1:0] v);
        return (v == IDX_LAST) ? '0 : v + 1'b1;
    endfunction

    function automatic logic [IDX_W-1:0] idx_dec(input logic [IDX_W-1:0] v);
        return (v == '0) ? IDX_LAST : v - 1'b1;
    endfunction

    assign req   = '{push: push, pop: pop};
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_MAX);
    assign op    = ras_decode(req, !empty);

    always_comb begin
        top_d   = top_q;
        cnt_d   = cnt_q;
        wr_en   = 1'b0;
        wr_idx  = top_q;
        pop_hit = 1'b0;
        unique case (op)
            OP_SWAP: begin
                pop_hit = 1'b1;
                wr_en   = 1'b1;
                wr_idx  = top_q;
            end
            OP_POP: begin
                pop_hit = 1'b1;
                top_d   = idx_dec(top_q);
                cnt_d   = cnt_q - 1'b1;
            end
            OP_PUSH: begin
                if (!full) begin
                    top_d  = idx_inc(top_q);
                    wr_idx = idx_inc(top_q);
                    wr_en  = 1'b1;
                    cnt_d  = cnt_q + 1'b1;
                end else if (POLICY == OVF_WRAP) begin
                    top_d  = idx_inc(top_q);
                    wr_idx = idx_inc(top_q);
                    wr_en  = 1'b1;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
            cnt_q <= '0;
        end else begin
            top_q <= top_d;
            cnt_q <= cnt_d;
        end
    end

    assign top_idx = top_q;

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
    parameter int                DEPTH  = 4,
    parameter ras_pkg::ras_ovf_e POLICY = ras_pkg::OVF_WRAP
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push_i,
    input  logic [ras_pkg::RAS_ADDR_W-1:0] push_pc_i,
    input  logic                         pop_i,
    output logic [ras_pkg::RAS_ADDR_W-1:0] pred_target_o,
    output logic                         pred_valid_o,
    output logic                         full_o,
    output logic                         empty_o
);
    import ras_pkg::*;

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;
    logic             wr_en;
    logic             pop_hit;
    ras_addr_t        top_data;
    ras_addr_t        ret_addr;

    assign ret_addr = ras_ret_addr(push_pc_i);

    ras_ptr_ctrl #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W),
        .POLICY(POLICY)
    ) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .push   (push_i),
        .pop    (pop_i),
        .top_idx(top_idx),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .pop_hit(pop_hit),
        .full   (full_o),
        .empty  (empty_o)
    );

    ras_store #(
        .DEPTH(DEPTH),
        .IDX_W(IDX_W)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(ret_addr),
        .rd_idx (top_idx),
        .rd_data(top_data)
    );

    assign pred_valid_o  = pop_hit;
    assign pred_target_o = pop_hit ? top_data : '0;

endmodule

// File: rtl/ras_checker.sv
module ras_checker (
    input logic clk,
    input logic rst,
    input logic push_i,
    input logic pop_i,
    input logic pred_valid_o,
    input logic full_o,
    input logic empty_o
);

    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (empty_o && !full_o && !pred_valid_o));

    assert_push_fills_R2: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && !full_o) |=> !empty_o);

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (rst)
        (pop_i && !push_i && empty_o) |=> empty_o);

    assert_flags_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));

    assert_full_sticks_R6_R7: assert property (@(posedge clk) disable iff (rst)
        (push_i && !pop_i && full_o) |=> full_o);

    assert_swap_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (push_i && pop_i && !empty_o) |=> ($stable(full_o) && $stable(empty_o)));

    assert_valid_needs_pop_R9: assert property (@(posedge clk) disable iff (rst)
        pred_valid_o |-> (pop_i && !empty_o));

endmodule

bind ret_addr_stack ras_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .pred_valid_o(pred_valid_o),
    .full_o      (full_o),
    .empty_o     (empty_o)
);

// File: tb/ret_addr_stack_tb.sv
module ret_addr_stack_tb;
    import ras_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push = 1'b0;
    logic [31:0] push_pc = '0;
    logic        pop = 1'b0;

    logic [31:0] w_tgt, d_tgt;
    logic        w_vld, d_vld, w_full, d_full, w_emp, d_emp;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ret_addr_stack #(.DEPTH(4), .POLICY(OVF_WRAP)) u_dut (
        .clk(clk), .rst(rst), .push_i(push), .push_pc_i(push_pc), .pop_i(pop),
        .pred_target_o(w_tgt), .pred_valid_o(w_vld), .full_o(w_full), .empty_o(w_emp));

    ret_addr_stack #(.DEPTH(4), .POLICY(OVF_DROP)) u_dut_drop (
        .clk(clk), .rst(rst), .push_i(push), .push_pc_i(push_pc), .pop_i(pop),
        .pred_target_o(d_tgt), .pred_valid_o(d_vld), .full_o(d_full), .empty_o(d_emp));

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // drive one cycle's request at the falling edge, then settle before the rising edge
    task automatic step(input logic ps, input logic [31:0] pc, input logic pp);
        @(negedge clk);
        push = ps; push_pc = pc; pop = pp;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; push = 1'b0; pop = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic pop_expect(input string req, input logic [31:0] exp_w, input logic [31:0] exp_d);
        step(1'b0, '0, 1'b1);
        chk({req, " wrap valid"}, 32'(w_vld), 32'd1);
        chk({req, " wrap target"}, w_tgt, exp_w);
        chk({req, " drop valid"}, 32'(d_vld), 32'd1);
        chk({req, " drop target"}, d_tgt, exp_d);
    endtask

    task automatic pop_none(input string req);
        step(1'b0, '0, 1'b1);
        chk({req, " wrap valid low"}, 32'(w_vld), 32'd0);
        chk({req, " drop valid low"}, 32'(d_vld), 32'd0);
    endtask

    task automatic t_reset();
        do_reset();
        step(1'b0, '0, 1'b0);
        chk("R1 empty", 32'(w_emp & d_emp), 32'd1);
        chk("R1 full", 32'(w_full | d_full), 32'd0);
        chk("R1 valid", 32'(w_vld | d_vld), 32'd0);
    endtask

    task automatic t_push_pop();
        step(1'b1, 32'h0000_FC34, 1'b0);
        step(1'b0, '0, 1'b0);
        chk("R2 not empty after push", 32'(w_emp), 32'd0);
        chk("R9 idle no valid", 32'(w_vld | d_vld), 32'd0);
        pop_expect("R2", 32'h0000_FC38, 32'h0000_FC38);
        step(1'b0, '0, 1'b0);
        chk("R5 empty after drain", 32'(w_emp & d_emp), 32'd1);
    endtask

    task automatic t_lifo();
        step(1'b1, 32'h1000_0000, 1'b0);
        step(1'b1, 32'h2000_0010, 1'b0);
        step(1'b1, 32'h3000_0020, 1'b0);
        pop_expect("R3 third", 32'h3000_0024, 32'h3000_0024);
        pop_expect("R3 second", 32'h2000_0014, 32'h2000_0014);
        pop_expect("R3 first", 32'h1000_0004, 32'h1000_0004);
        pop_none("R3 drained");
    endtask

    task automatic t_pop_empty();
        pop_none("R4 empty pop");
        pop_none("R4 empty pop again");
        step(1'b0, '0, 1'b0);
        chk("R4 still empty", 32'(w_emp & d_emp), 32'd1);
        step(1'b1, 32'h0000_ABC0, 1'b0);
        pop_expect("R4 push after empty pop", 32'h0000_ABC4, 32'h0000_ABC4);
        pop_none("R4 drained");
    endtask

    task automatic t_overflow();
        for (int i = 1; i <= 4; i++) step(1'b1, 32'(i * 32'h100), 1'b0);
        step(1'b0, '0, 1'b0);
        chk("R5 wrap full", 32'(w_full), 32'd1);
        chk("R5 drop full", 32'(d_full), 32'd1);
        step(1'b1, 32'h500, 1'b0);
        step(1'b0, '0, 1'b0);
        chk("R6 wrap full kept", 32'(w_full), 32'd1);
        chk("R7 drop full kept", 32'(d_full), 32'd1);
        pop_expect("R6 R7 pop1", 32'h504, 32'h404);
        pop_expect("R6 R7 pop2", 32'h404, 32'h304);
        pop_expect("R6 R7 pop3", 32'h304, 32'h204);
        pop_expect("R6 R7 pop4", 32'h204, 32'h104);
        pop_none("R6 R7 after depth pops");
        step(1'b0, '0, 1'b0);
        chk("R6 wrap empty", 32'(w_emp), 32'd1);
    endtask

    task automatic t_swap();
        step(1'b1, 32'h0000_7000, 1'b0);
        step(1'b1, 32'h0000_8000, 1'b0);
        step(1'b1, 32'h0000_9000, 1'b1);
        chk("R8 swap valid", 32'(w_vld & d_vld), 32'd1);
        chk("R8 swap old top", w_tgt, 32'h0000_8004);
        pop_expect("R8 replaced top", 32'h0000_9004, 32'h0000_9004);
        pop_expect("R8 lower kept", 32'h0000_7004, 32'h0000_7004);
        pop_none("R8 drained");
        step(1'b1, 32'h0000_A000, 1'b1);
        chk("R8 empty swap invalid", 32'(w_vld | d_vld), 32'd0);
        pop_expect("R8 empty swap pushed", 32'h0000_A004, 32'h0000_A004);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        t_reset();
        t_push_pop();
        t_lifo();
        t_pop_empty();
        t_overflow();
        t_reset();
        t_swap();
        step(1'b0, '0, 1'b0);
        finish_run();
    end

endmodule